// File: doc/BRIEF.md
# Receive Frame Completion Status Tracker

This block sits between the receive byte queue of a frame-based serial receiver and the host bus. Incoming bytes arrive with a frame-start mark and an end-of-frame mark. Each stored byte carries two tags: an end-of-frame tag and an overrun tag. The host drains bytes one at a time from the head of the queue. When the host drains the byte that ends a frame, the block latches a frame record. The record holds the frame's byte count and an overrun flag. At the same time the block raises a sticky frame-done status bit, which also drives an interrupt line.

An overrun is a byte that arrives while the queue is full. The block handles it according to where it falls. If the overrun lands in the middle of a frame, the byte is dropped and the newest stored byte is tagged as overrun. If the newest stored byte already ends the previous frame, there is no byte of the new frame to tag. In that case the block raises a frame-lost status bit and throws away the whole new frame.

The status bits follow three different clear rules. Frame-done clears only when the host reads the frame record. The other event bits are cleared by writing a 1 to their bit. A record that is overwritten before the host reads it raises a record-lost bit.

Top module: `rxFrameTracker`

## Requirements
- R1: After reset, `statusOut` is 0, `frameIrq` is 0, `fifoEmpty` is 1, `fifoFull` is 0 and `recordOut` is 0.
- R2: The queue holds 16 entries and returns bytes in arrival order. `dataOut` shows the head entry. `fifoFull` is 1 when 16 entries are stored. `fifoEmpty` is 1 when no entries are stored. A `rdData` pulse while the queue is empty changes nothing.
- R3: Draining an entry that carries the end-of-frame tag sets status bit 0 (frame done) at the next edge. `frameIrq` equals status bit 0.
- R4: The same drain loads `recordOut`. Bits [11:0] hold the number of bytes drained for that frame, including the last byte. The byte count restarts after every end-of-frame drain.
- R5: Status bit 0 clears one cycle after a `rdRecord` pulse. Writing 1 to bit 0 has no effect. If an end-of-frame drain and a `rdRecord` pulse happen in the same cycle, the bit ends up set.
- R6: Status bit 1 (record lost) is set when an end-of-frame drain happens while bit 0 is already set and `rdRecord` is not pulsed in that cycle.
- R7: When a byte arrives at a full queue and the newest entry has no end-of-frame tag, the byte is dropped and the newest entry gets the overrun tag. The overrun tag is reported in `recordOut` bit 12. That bit is 1 if any drained byte of the frame had the overrun tag.
- R8: When a byte arrives at a full queue and the newest entry has the end-of-frame tag, status bit 2 (frame lost) is set. The byte is dropped. Every following byte is also dropped, up to and including the next byte marked end-of-frame.
- R9: Status bits 1 to 6 are sticky. Each clears only when `stWrEn` is pulsed with a 1 in that bit of `stWrData`. Writing 0 has no effect. A set event in the same cycle wins over the clear. Bit 7 always reads 0.
- R10: Status bit 3 (frame start) is set by any `wrValid` byte that has `wrSof` high, whether or not the byte is stored. `txEvent` bits 0, 1 and 2 set status bits 4 (tx start), 5 (tx done) and 6 (tx abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Incoming byte valid |
| wrData | input | 8 | Incoming byte |
| wrEof | input | 1 | Incoming byte ends a frame |
| wrSof | input | 1 | Incoming byte begins a frame |
| rdData | input | 1 | Drain the head entry |
| dataOut | output | 8 | Head entry byte |
| fifoEmpty | output | 1 | Queue empty |
| fifoFull | output | 1 | Queue full |
| rdRecord | input | 1 | Host reads the frame record |
| recordOut | output | 13 | Frame record: overrun flag in bit 12, byte count in bits 11:0 |
| stWrEn | input | 1 | Status write strobe |
| stWrData | input | 8 | Status write data (write 1 to clear) |
| statusOut | output | 8 | Status bits |
| txEvent | input | 3 | Transmit-side event pulses |
| frameIrq | output | 1 | Frame-done interrupt |

## Verification
The first pattern is a single frame drained and then acknowledged. It shows that the frame-done bit is set and cleared correctly, and that the byte count is exact. The second pattern drains two short frames back to back without reading the record. It checks that record loss is judged on the frame-done bit at drain time. The third pattern fills the queue mid-frame and then overruns it. The fourth fills the queue so that an end-of-frame entry is newest and then overruns it. Together these two show the difference between tagging the newest entry and discarding the whole frame. A long stretch of random traffic then mixes drains, record reads, clears and overruns. It is compared every cycle against a queue-based model, which exposes ordering errors and set-versus-clear priority errors.

// File: rtl/rxTrkPkg.sv
package rxTrkPkg;
  localparam int STAT_W  = 8;
  localparam int B_DONE  = 0;
  localparam int B_RLOST = 1;
  localparam int B_FLOST = 2;
  localparam int B_FSTRT = 3;
  localparam int B_TX    = 4;

  typedef struct packed {
    logic push;
    logic pop;
    logic markOvr;
    logic frameEnd;
  } rxStrobeT;
endpackage

// File: rtl/rxTrkDatapath.sv
module rxTrkDatapath
  import rxTrkPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEof,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W:0]    recordOut,
  output logic              full,
  output logic              empty,
  output logic              headEof,
  output logic              tailEof
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  eofMem;
  logic [DEPTH-1:0]  ovrMem;
  logic [AW-1:0]     rdPtr, wrPtr, lastIdx;
  logic [AW:0]       fill;
  logic [CNT_W-1:0]  byteCnt;
  logic              ovrSeen;

  assign lastIdx = (wrPtr == '0) ? LAST : wrPtr - 1'b1;
  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign dataOut = dataMem[rdPtr];
  assign headEof = eofMem[rdPtr];
  assign tailEof = eofMem[lastIdx];

  always_ff @(posedge clk) begin
    if (strobe.push) dataMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eofMem <= '0;
      ovrMem <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
      fill   <= '0;
    end else begin
      if (strobe.markOvr) ovrMem[lastIdx] <= 1'b1;
      if (strobe.push) begin
        eofMem[wrPtr] <= wrEof;
        ovrMem[wrPtr] <= 1'b0;
        wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.pop) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      ovrSeen   <= 1'b0;
      recordOut <= '0;
    end else if (strobe.pop) begin
      if (strobe.frameEnd) begin
        recordOut <= {ovrSeen | ovrMem[rdPtr], byteCnt + 1'b1};
        byteCnt   <= '0;
        ovrSeen   <= 1'b0;
      end else begin
        byteCnt <= byteCnt + 1'b1;
        ovrSeen <= ovrSeen | ovrMem[rdPtr];
      end
    end
  end
endmodule

// File: rtl/rxTrkControl.sv
module rxTrkControl
  import rxTrkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrEof,
  input  logic              wrSof,
  input  logic              rdData,
  input  logic              rdRecord,
  input  logic              stWrEn,
  input  logic [STAT_W-1:0] stWrData,
  input  logic [2:0]        txEvent,
  input  logic              full,
  input  logic              empty,
  input  logic              headEof,
  input  logic              tailEof,
  output rxStrobeT          strobe,
  output logic [STAT_W-1:0] status
);
  logic discard, overrun, lostStart;
  logic [STAT_W-1:0] statusNxt;

  assign overrun   = wrValid && full && !discard;
  assign lostStart = overrun && tailEof;

  always_comb begin
    strobe.push     = wrValid && !full && !discard;
    strobe.pop      = rdData && !empty;
    strobe.frameEnd = strobe.pop && headEof;
    strobe.markOvr  = overrun && !tailEof;
  end

  always_comb begin
    statusNxt = status;
    if (stWrEn) statusNxt[B_TX+2:B_RLOST] = status[B_TX+2:B_RLOST] & ~stWrData[B_TX+2:B_RLOST];
    if (rdRecord) statusNxt[B_DONE] = 1'b0;
    if (strobe.frameEnd) begin
      statusNxt[B_DONE] = 1'b1;
      if (status[B_DONE] && !rdRecord) statusNxt[B_RLOST] = 1'b1;
    end
    if (lostStart) statusNxt[B_FLOST] = 1'b1;
    if (wrValid && wrSof) statusNxt[B_FSTRT] = 1'b1;
    statusNxt[B_TX +: 3] = statusNxt[B_TX +: 3] | txEvent;
    statusNxt[STAT_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= '0;
      discard <= 1'b0;
    end else begin
      status <= statusNxt;
      if (discard && wrValid && wrEof) discard <= 1'b0;
      else if (lostStart && !wrEof)    discard <= 1'b1;
    end
  end
endmodule

// File: rtl/rxFrameTracker.sv
module rxFrameTracker
  import rxTrkPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEof,
  input  logic              wrSof,
  input  logic              rdData,
  output logic [DATA_W-1:0] dataOut,
  output logic              fifoEmpty,
  output logic              fifoFull,
  input  logic              rdRecord,
  output logic [CNT_W:0]    recordOut,
  input  logic              stWrEn,
  input  logic [7:0]        stWrData,
  output logic [7:0]        statusOut,
  input  logic [2:0]        txEvent,
  output logic              frameIrq
);
  rxStrobeT strobe;
  logic headEof, tailEof;

  rxTrkControl uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrEof(wrEof), .wrSof(wrSof),
    .rdData(rdData), .rdRecord(rdRecord), .stWrEn(stWrEn), .stWrData(stWrData),
    .txEvent(txEvent), .full(fifoFull), .empty(fifoEmpty), .headEof(headEof),
    .tailEof(tailEof), .strobe(strobe), .status(statusOut)
  );

  rxTrkDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrEof(wrEof),
    .dataOut(dataOut), .recordOut(recordOut), .full(fifoFull), .empty(fifoEmpty),
    .headEof(headEof), .tailEof(tailEof)
  );

  assign frameIrq = statusOut[B_DONE];
endmodule

// File: rtl/rxTrkChecker.sv
module rxTrkChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic       rdData,
  input logic       rdRecord,
  input logic       stWrEn,
  input logic [7:0] stWrData,
  input logic       fifoEmpty,
  input logic       fifoFull,
  input logic       headEof,
  input logic [7:0] statusOut
);
  logic eofDrain;
  assign eofDrain = rdData && !fifoEmpty && headEof;

  p_done_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    eofDrain |=> statusOut[0]);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdRecord && !eofDrain) |=> !statusOut[0]);

  p_rec_lost_r6: assert property (@(posedge clk) disable iff (!rstN)
    (eofDrain && statusOut[0] && !rdRecord) |=> statusOut[1]);

  p_frame_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[2] && !(stWrEn && stWrData[2])) |=> statusOut[2]);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrValid && !rdData) |=> fifoFull);

  p_empty_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && rdData && !wrValid) |=> fifoEmpty);

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    stWrEn |=> !statusOut[7]);
endmodule

bind rxFrameTracker rxTrkChecker uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdData(rdData), .rdRecord(rdRecord),
  .stWrEn(stWrEn), .stWrData(stWrData), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
  .headEof(headEof), .statusOut(statusOut)
);

// File: tb/tb_rxFrameTracker.sv
`timescale 1ns/1ps
module tb_rxFrameTracker;
  logic clk = 0, rstN = 0;
  logic wrValid = 0, wrEof = 0, wrSof = 0, rdData = 0, rdRecord = 0, stWrEn = 0;
  logic [7:0] wrData = 0, stWrData = 0, dataOut, statusOut;
  logic [2:0] txEvent = 0;
  logic fifoEmpty, fifoFull, frameIrq;
  logic [12:0] recordOut;

  int nChk = 0, nFail = 0;
  bit done = 0, running = 0;

  rxFrameTracker dut (.*);

  always #2 clk = ~clk;

  // reference model state
  int qd[$], qe[$], qo[$];
  int mCnt, mAcc, mRecCnt, mRecOvr;
  bit mDisc;
  bit [7:0] mSt;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      qd.delete(); qe.delete(); qo.delete();
      mCnt = 0; mAcc = 0; mRecCnt = 0; mRecOvr = 0; mDisc = 0; mSt = 0;
    end else begin
      int n; bit full, tailE, pop, eofP, ovr, push, lost; bit [7:0] s;
      n = qd.size(); full = (n == 16); tailE = (n > 0) ? qe[n-1] : 0;
      pop = rdData && n > 0; eofP = pop && qe[0];
      ovr = wrValid && full && !mDisc; push = wrValid && !full && !mDisc;
      lost = ovr && tailE;
      s = mSt;
      if (stWrEn) s[6:1] = s[6:1] & ~stWrData[6:1];
      if (rdRecord) s[0] = 0;
      if (eofP) begin s[0] = 1; if (mSt[0] && !rdRecord) s[1] = 1; end
      if (lost) s[2] = 1;
      if (wrValid && wrSof) s[3] = 1;
      s[6:4] = s[6:4] | txEvent;
      mSt = s;
      if (mDisc && wrValid && wrEof) mDisc = 0;
      else if (lost && !wrEof) mDisc = 1;
      if (ovr && !tailE) qo[n-1] = 1;
      if (pop) begin
        if (qe[0]) begin
          mRecCnt = (mCnt + 1) % 4096; mRecOvr = mAcc | qo[0]; mCnt = 0; mAcc = 0;
        end else begin
          mCnt++; mAcc = mAcc | qo[0];
        end
        void'(qd.pop_front()); void'(qe.pop_front()); void'(qo.pop_front());
      end
      if (push) begin qd.push_back(wrData); qe.push_back(wrEof); qo.push_back(0); end
    end
  end

  always @(negedge clk) begin
    if (running && rstN) begin
      chk("R2 empty", fifoEmpty, qd.size() == 0);
      chk("R2 full", fifoFull, qd.size() == 16);
      if (qd.size() > 0) chk("R2 head data", dataOut, qd[0]);
      chk("R3 frame done bit", statusOut[0], mSt[0]);
      chk("R3 irq", frameIrq, mSt[0]);
      chk("R6 record lost bit", statusOut[1], mSt[1]);
      chk("R8 frame lost bit", statusOut[2], mSt[2]);
      chk("R10 frame start/tx bits", statusOut[6:3], mSt[6:3]);
      chk("R9 reserved bit", statusOut[7], 0);
      chk("R4 record count", recordOut[11:0], mRecCnt);
      chk("R7 record overrun", recordOut[12], mRecOvr);
    end
  end

  task automatic cyc(input bit v = 0, input int d = 0, input bit e = 0, input bit s = 0,
                     input bit rd = 0, input bit rr = 0, input bit sw = 0,
                     input int sd = 0, input int tx = 0);
    wrValid = v; wrData = 8'(d); wrEof = e; wrSof = s; rdData = rd; rdRecord = rr;
    stWrEn = sw; stWrData = 8'(sd); txEvent = 3'(tx);
    @(negedge clk);
  endtask

  task automatic sendFrame(input int len, input int base);
    for (int i = 0; i < len; i++) cyc(1, base + i, i == len - 1, i == 0);
  endtask

  task automatic drain(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", statusOut, 0);
    chk("R1 irq", frameIrq, 0);
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 full", fifoFull, 0);
    chk("R1 record", recordOut, 0);
    running = 1;

    // single frame, drain, acknowledge
    sendFrame(3, 8'h10);
    drain(3);
    chk("R4 count three", recordOut[11:0], 3);
    chk("R3 done set", statusOut[0], 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h01);           // writing 1 to bit 0 does nothing
    chk("R5 w1 on done ignored", statusOut[0], 1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R5 done cleared by record read", statusOut[0], 0);

    // two short frames without record read -> record lost
    sendFrame(1, 8'h20);
    sendFrame(2, 8'h30);
    drain(3);
    chk("R6 record lost", statusOut[1], 1);
    chk("R4 count two", recordOut[11:0], 2);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);
    chk("R9 write zero keeps", statusOut[1], 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h02);
    chk("R9 w1c clears", statusOut[1], 0);

    // eof drain with record read in same cycle
    sendFrame(1, 8'h40);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R5 set wins over read", statusOut[0], 1);
    chk("R6 no loss when read same cycle", statusOut[1], 0);
    cyc(0, 0, 0, 0, 0, 1);

    // mid-frame overrun
    for (int i = 0; i < 16; i++) cyc(1, 8'h50 + i, 0, i == 0);
    cyc(1, 8'hee); cyc(1, 8'hef);
    chk("R2 full after 16", fifoFull, 1);
    drain(16);
    cyc(1, 8'h77, 1);
    drain(1);
    chk("R7 overrun flag in record", recordOut[12], 1);
    chk("R4 count seventeen", recordOut[11:0], 17);
    drain(2);                                   // drains on empty
    chk("R2 empty pop ignored", fifoEmpty, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // overrun at frame boundary
    for (int f = 0; f < 4; f++) sendFrame(4, 8'h80 + 4 * f);
    sendFrame(3, 8'hc0);
    chk("R8 frame lost", statusOut[2], 1);
    sendFrame(2, 8'hd0);                        // still full, newest has eof -> lost again
    drain(16);
    sendFrame(2, 8'he0);
    drain(2);
    chk("R8 next frame kept", recordOut[11:0], 2);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'hfe, 3'b111);
    chk("R9 set wins over clear", statusOut[6:4], 3'b111);
    cyc(0, 0, 0, 0, 0, 0, 1, 8'hfe);
    chk("R10 tx and start bits cleared", statusOut[6:3], 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      cyc(r[0] | r[1], r[15:8], r[4:2] == 0, r[7:5] == 0, r[16] & r[17] | r[18] & r[19] & r[20],
          r[21:23] == 0, r[24] & r[25] & r[26], r[31:24], (r[29:27] == 0) ? 1 << r[31:30] : 0);
    end
    cyc();
    running = 0;
    finishRun();
  end
endmodule